// File: doc/BRIEF.md
# Eight-Bit Accumulator ALU With Flag Word

This block is a purely combinational arithmetic and logic unit for an eight-bit accumulator datapath. Each cycle it takes the accumulator value, a second operand, the current carry flag and an operation code. It returns three things: the new accumulator value, a strobe that says whether the accumulator should be written, and a complete eight-bit flag word. The surrounding core registers the result and the flags. The block has no clock and no state, so its outputs settle in the same cycle as its inputs.

The flag word carries the usual sign, zero and carry bits. It also carries a half-carry for decimal correction and an add/subtract marker. One bit is shared: it reports signed overflow for arithmetic operations and even parity for logic operations. Two further bits mirror bits 5 and 3 of the result. A compare runs the subtract path to produce flags only. Increment and decrement pass the incoming carry through unchanged.

Top module: `alu8_core`

## Requirements
- R1: The flag word holds, from bit 7 down to bit 0: S, Z, X5, H, X3, PV, N, C. S equals result bit 7, and Z is 1 exactly when the 8-bit result is zero.
- R2: Flag bits 5 and 3 copy result bits 5 and 3. For a compare they copy bits 5 and 3 of the operand instead.
- R3: ADD (op 0) returns acc+opnd and ADC (op 1) returns acc+opnd+cin, both modulo 256. N=0, C is the carry out of bit 7, and PV is set on two's-complement overflow.
- R4: SUB (op 2) returns acc-opnd and SBC (op 3) returns acc-opnd-cin, both modulo 256. N=1, C is the borrow out of bit 7, and PV is set on two's-complement overflow.
- R5: CP (op 4) produces the same result and S, Z, H, PV, N, C flags as SUB, but the write strobe is 0.
- R6: For arithmetic operations H is the carry out of bit 3 (add, increment) or the borrow out of bit 3 (subtract, compare, decrement).
- R7: AND (op 5) returns acc AND opnd with H=1, N=0, C=0, and PV=1 when the result has an even number of ones.
- R8: OR (op 6) and XOR (op 7) return the bitwise result with H=0, N=0, C=0, and PV set for even parity.
- R9: INC (op 8) returns acc+1 and DEC (op 9) returns acc-1. The operand is ignored and C equals cin. INC gives N=0 and PV=1 only for 0x7F to 0x80; DEC gives N=1 and PV=1 only for 0x80 to 0x7F.
- R10: Op codes 10 to 15 are unused. They give write strobe 0, result equal to acc, and a flag word of zero except C, which equals cin.
- R11: The write strobe is 1 for every defined operation except CP.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| acc_i | input | 8 | Accumulator value |
| opnd_i | input | 8 | Second operand |
| cin_i | input | 1 | Current carry flag |
| op_i | input | 4 | Operation code |
| res_o | output | 8 | Operation result |
| wr_o | output | 1 | Accumulator write strobe |
| flags_o | output | 8 | Flag word S,Z,X5,H,X3,PV,N,C |

## Verification
The in-line assertions assume that every input is at a known two-state value whenever the outputs are evaluated. They also assume that an op code above 9 carries no hidden meaning, because the fixed-flag and write-strobe checks apply only to defined codes. The stimulus always applies complete, defined input vectors with no X or Z bits. It covers every operand pair and both carry values for each defined operation, and it runs a separate sweep that exercises the unused codes.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned DW = 8;
  localparam int unsigned OPW = 4;

  typedef enum logic [OPW-1:0] {
    OP_ADD = 4'd0,
    OP_ADC = 4'd1,
    OP_SUB = 4'd2,
    OP_SBC = 4'd3,
    OP_CP  = 4'd4,
    OP_AND = 4'd5,
    OP_OR  = 4'd6,
    OP_XOR = 4'd7,
    OP_INC = 4'd8,
    OP_DEC = 4'd9
  } alu_op_e;

  localparam int unsigned FL_S  = 7;
  localparam int unsigned FL_Z  = 6;
  localparam int unsigned FL_X5 = 5;
  localparam int unsigned FL_H  = 4;
  localparam int unsigned FL_X3 = 3;
  localparam int unsigned FL_PV = 2;
  localparam int unsigned FL_N  = 1;
  localparam int unsigned FL_C  = 0;

  typedef enum logic [1:0] {
    LG_AND = 2'd0,
    LG_OR  = 2'd1,
    LG_XOR = 2'd2
  } logic_sel_e;
endpackage

// File: rtl/alu8_addsub.sv
module alu8_addsub #(
  parameter int unsigned W  = 8,
  parameter int unsigned HB = 4
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         cb_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cy_o,
  output logic         half_o,
  output logic         ovf_o
);
  localparam int unsigned MW = W - 1 - HB;

  logic [W-1:0]  bx;
  logic          cx;
  logic [HB:0]   lo;
  logic [MW:0]   mid;
  logic [1:0]    top;

  always_comb begin
    bx  = sub_i ? ~b_i : b_i;
    cx  = sub_i ? ~cb_i : cb_i;
    lo  = {1'b0, a_i[HB-1:0]} + {1'b0, bx[HB-1:0]} + {{HB{1'b0}}, cx};
    mid = {1'b0, a_i[W-2:HB]} + {1'b0, bx[W-2:HB]} + {{MW{1'b0}}, lo[HB]};
    top = {1'b0, a_i[W-1]} + {1'b0, bx[W-1]} + {1'b0, mid[MW]};
    sum_o  = {top[0], mid[MW-1:0], lo[HB-1:0]};
    cy_o   = sub_i ? ~top[1] : top[1];
    half_o = sub_i ? ~lo[HB] : lo[HB];
    ovf_o  = mid[MW] ^ top[1];
  end
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic_sel_e   sel_i,
  output logic [W-1:0] res_o,
  output logic         even_o
);
  logic [W:0] fold;

  always_comb begin
    unique case (sel_i)
      LG_AND:  res_o = a_i & b_i;
      LG_OR:   res_o = a_i | b_i;
      default: res_o = a_i ^ b_i;
    endcase
  end

  assign fold[0] = 1'b1;
  for (genvar i = 0; i < W; i++) begin : g_par
    assign fold[i+1] = fold[i] ^ res_o[i];
  end
  assign even_o = fold[W];
endmodule

// File: rtl/alu8_core.sv
module alu8_core
  import alu8_pkg::*;
(
  input  logic [7:0] acc_i,
  input  logic [7:0] opnd_i,
  input  logic       cin_i,
  input  logic [3:0] op_i,
  output logic [7:0] res_o,
  output logic       wr_o,
  output logic [7:0] flags_o
);
  alu_op_e     op_e;
  logic [DW-1:0] as_b;
  logic        as_c;
  logic        as_sub;
  logic [DW-1:0] as_sum;
  logic        as_cy, as_half, as_ovf;
  logic_sel_e  lg_sel;
  logic [DW-1:0] lg_res;
  logic        lg_even;
  logic        is_arith, is_logic, is_step, defined;

  assign op_e = alu_op_e'(op_i);

  always_comb begin
    as_b   = opnd_i;
    as_c   = 1'b0;
    as_sub = 1'b0;
    lg_sel = LG_XOR;
    unique case (op_e)
      OP_ADC: as_c = cin_i;
      OP_SUB, OP_CP: as_sub = 1'b1;
      OP_SBC: begin as_sub = 1'b1; as_c = cin_i; end
      OP_INC: as_b = DW'(1);
      OP_DEC: begin as_b = DW'(1); as_sub = 1'b1; end
      OP_AND: lg_sel = LG_AND;
      OP_OR:  lg_sel = LG_OR;
      default: ;
    endcase
  end

  alu8_addsub #(.W(DW), .HB(4)) u_as (
    .a_i(acc_i), .b_i(as_b), .cb_i(as_c), .sub_i(as_sub),
    .sum_o(as_sum), .cy_o(as_cy), .half_o(as_half), .ovf_o(as_ovf)
  );

  alu8_logic #(.W(DW)) u_lg (
    .a_i(acc_i), .b_i(opnd_i), .sel_i(lg_sel),
    .res_o(lg_res), .even_o(lg_even)
  );

  always_comb begin
    is_arith = op_i <= 4'd4;
    is_logic = (op_e == OP_AND) || (op_e == OP_OR) || (op_e == OP_XOR);
    is_step  = (op_e == OP_INC) || (op_e == OP_DEC);
    defined  = is_arith || is_logic || is_step;

    res_o   = acc_i;
    wr_o    = 1'b0;
    flags_o = '0;
    flags_o[FL_C] = cin_i;

    if (defined) begin
      res_o = is_logic ? lg_res : as_sum;
      wr_o  = (op_e != OP_CP);
      flags_o[FL_S]  = res_o[7];
      flags_o[FL_Z]  = ~|res_o;
      flags_o[FL_X5] = (op_e == OP_CP) ? opnd_i[5] : res_o[5];
      flags_o[FL_X3] = (op_e == OP_CP) ? opnd_i[3] : res_o[3];
      if (is_logic) begin
        flags_o[FL_H]  = (op_e == OP_AND);
        flags_o[FL_PV] = lg_even;
        flags_o[FL_N]  = 1'b0;
        flags_o[FL_C]  = 1'b0;
      end else begin
        flags_o[FL_H]  = as_half;
        flags_o[FL_PV] = as_ovf;
        flags_o[FL_N]  = as_sub;
        flags_o[FL_C]  = is_step ? cin_i : as_cy;
      end
    end
  end

  always_comb begin
    a_r1_zero_flag: assert (op_i > 4'd9 || flags_o[FL_Z] == (res_o == 8'h00));
    a_r3_add_overflow: assert (!(op_e == OP_ADD || op_e == OP_ADC) ||
      flags_o[FL_PV] == ((acc_i[7] == opnd_i[7]) && (res_o[7] != acc_i[7])));
    a_r5_cp_no_write: assert (op_e != OP_CP || !wr_o);
    a_r7_and_fixed: assert (op_e != OP_AND ||
      (flags_o[FL_H] && !flags_o[FL_N] && !flags_o[FL_C]));
    a_r8_parity: assert (!(op_e == OP_OR || op_e == OP_XOR) ||
      flags_o[FL_PV] == ~^res_o);
    a_r9_carry_kept: assert (!(op_e == OP_INC || op_e == OP_DEC) ||
      flags_o[FL_C] == cin_i);
    a_r10_unused_idle: assert (op_i <= 4'd9 ||
      (!wr_o && res_o == acc_i && flags_o == {7'd0, cin_i}));
    a_r11_write_strobe: assert (op_i > 4'd9 || op_e == OP_CP || wr_o);
  end
endmodule

// File: tb/sim_alu8_core.sv
`timescale 1ns/1ps
module sim_alu8_core;
  logic       clk = 1'b0;
  logic [7:0] acc, opnd;
  logic       cin;
  logic [3:0] op;
  logic [7:0] res, flags;
  logic       wr;
  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit done = 0;

  always #10 clk = ~clk;

  alu8_core u0 (
    .acc_i(acc), .opnd_i(opnd), .cin_i(cin), .op_i(op),
    .res_o(res), .wr_o(wr), .flags_o(flags)
  );

  function automatic logic [16:0] model(input int o, input int a, input int b, input int c);
    int r, h, v, cy, n, sa, sb, sr, full, pv;
    logic [7:0] r8, f;
    logic w;
    sa = (a > 127) ? a - 256 : a;
    sb = (b > 127) ? b - 256 : b;
    h = 0; v = 0; cy = 0; n = 0; w = 1;
    if (o == 8) begin b = 1; sb = 1; c = 0; end
    if (o == 9) begin b = 1; sb = 1; c = 0; end
    if (o == 0 || o == 1 || o == 8) begin
      if (o == 0) c = (o == 8) ? 0 : 0;
      full = a + b + c; r = full % 256; cy = (full > 255);
      h = ((a % 16) + (b % 16) + c) > 15;
      sr = sa + sb + c; v = (sr > 127 || sr < -128);
    end else if (o == 2 || o == 3 || o == 4 || o == 9) begin
      if (o == 2 || o == 4) c = 0;
      full = a - b - c; r = (full + 512) % 256; cy = (full < 0);
      h = ((a % 16) - (b % 16) - c) < 0;
      sr = sa - sb - c; v = (sr > 127 || sr < -128); n = 1;
      if (o == 4) w = 0;
    end else if (o >= 5 && o <= 7) begin
      r8 = (o == 5) ? (a[7:0] & b[7:0]) : (o == 6) ? (a[7:0] | b[7:0]) : (a[7:0] ^ b[7:0]);
      r = r8;
      h = (o == 5);
      pv = 0;
      for (int k = 0; k < 8; k++) pv += r8[k];
      v = (pv % 2 == 0);
    end else begin
      r8 = a[7:0];
      return {1'b0, r8, 7'd0, cin};
    end
    r8 = r[7:0];
    f[7] = r8[7];
    f[6] = (r8 == 0);
    f[5] = (o == 4) ? b[5] : r8[5];
    f[3] = (o == 4) ? b[3] : r8[3];
    f[4] = h[0];
    f[2] = v[0];
    f[1] = n[0];
    f[0] = (o == 8 || o == 9) ? cin : cy[0];
    return {w, r8, f};
  endfunction

  function automatic string tag_of(input int o);
    case (o)
      0, 1: return "R3";
      2, 3: return "R4";
      4: return "R5";
      5: return "R7";
      6, 7: return "R8";
      8, 9: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic directed(input string tg, input int o, input int a, input int b,
                          input int c, input logic w_e, input logic [7:0] r_e,
                          input logic [7:0] f_e);
    op = o[3:0]; acc = a[7:0]; opnd = b[7:0]; cin = c[0];
    #1;
    total++;
    if (wr !== w_e || res !== r_e || flags !== f_e) begin
      bad++;
      $display("FAIL %s op=%0d a=%02h b=%02h: got wr=%b res=%02h flags=%02h exp wr=%b res=%02h flags=%02h",
               tg, o, a, b, wr, res, flags, w_e, r_e, f_e);
    end
  endtask

  task automatic sweep(input int o, input int c);
    logic [16:0] exp, got;
    bit first = 1;
    total++;
    cin = c[0]; op = o[3:0];
    for (int a = 0; a < 256; a++) begin
      for (int b = 0; b < 256; b++) begin
        acc = a[7:0]; opnd = b[7:0];
        #1;
        exp = model(o, a, b, c);
        got = {wr, res, flags};
        if (got !== exp && first) begin
          first = 0;
          bad++;
          $display("FAIL %s op=%0d cin=%0d a=%02h b=%02h: got %05h exp %05h",
                   tag_of(o), o, c, a, b, got, exp);
        end
      end
    end
  endtask

  initial begin
    acc = 0; opnd = 0; cin = 0; op = 0;
    #5;
    // initial state: ADD of zeros -> result 0, Z set, write
    directed("R1", 0, 0, 0, 0, 1'b1, 8'h00, 8'h40);
    // R1: 0x80+0x80 -> 0, Z, overflow, carry
    directed("R1", 0, 8'h80, 8'h80, 0, 1'b1, 8'h00, 8'h45);
    // R2: compare takes bits 5,3 from the operand
    directed("R2", 4, 8'h00, 8'h28, 0, 1'b0, 8'hD8, 8'hBB);
    // R6: half carry from 0x0F+0x01
    directed("R6", 0, 8'h0F, 8'h01, 0, 1'b1, 8'h10, 8'h10);
    // R9: INC 0x7F -> 0x80 overflow, carry kept at 1, operand ignored
    directed("R9", 8, 8'h7F, 8'hFF, 1, 1'b1, 8'h80, 8'h95);
    // R9: DEC 0x80 -> 0x7F overflow, N=1, H borrow
    directed("R9", 9, 8'h80, 8'h00, 0, 1'b1, 8'h7F, 8'h3E);
    // R11: AND writes the accumulator
    directed("R11", 5, 8'hF0, 8'h3C, 0, 1'b1, 8'h30, 8'h34);
    // R10: unused code leaves acc, only carry in flags
    directed("R10", 12, 8'hA5, 8'h5A, 1, 1'b0, 8'hA5, 8'h01);
    for (int o = 0; o < 10; o++)
      for (int c = 0; c < 2; c++)
        sweep(o, c);
    for (int o = 10; o < 16; o++) begin
      logic [16:0] exp;
      bit first = 1;
      total++;
      op = o[3:0];
      for (int a = 0; a < 256; a++) begin
        acc = a[7:0]; opnd = a[7:0] ^ 8'h5A; cin = a[0];
        #1;
        exp = {1'b0, a[7:0], 7'd0, a[0]};
        if ({wr, res, flags} !== exp && first) begin
          first = 0; bad++;
          $display("FAIL R10 op=%0d a=%02h: got %05h exp %05h", o, a, {wr, res, flags}, exp);
        end
      end
    end
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 150000 && !done) begin
      done = 1;
      total++;
      bad++;
      $display("FAIL watchdog: got %0d cycles exp completion", cycles);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule